// File: doc/BRIEF.md
# Single-Line Writeback Buffer

This block holds one dirty cache line on its way from a cache's eviction path to memory. When the cache evicts a dirty line, the line and its address are captured in one cycle and the cache is free to carry on at once. The buffer then writes the line to memory by itself. It keeps the write request asserted until memory acknowledges it, and only then releases the line.

While the line is waiting to drain, the cache can keep serving other addresses. A read lookup that falls in the buffered line is answered directly from the buffer, with the full line as data. A write lookup that falls in the buffered line is reported as a match but not as a hit, so the cache treats it as a miss. Such a write never stalls the cache and never modifies the buffered data. The cache is told to stall only when a second eviction arrives while the buffer is still holding a line that memory has not yet acknowledged. If the acknowledgement arrives in the same cycle as the new eviction, the new line is accepted at once.

Top module: `wb_line_buf`

## Requirements
- R1: After reset the buffer is empty: `buf_full`, `mem_wr_valid`, `ev_stall` and `lk_hit` are all 0.
- R2: An eviction offered while `buf_full` is 0 is captured at the clock edge. In the next cycle `buf_full` and `mem_wr_valid` are 1. `mem_wr_addr` is the eviction byte address with its low log2(LINE_BYTES) bits (bits 5:0 by default) forced to zero, and `mem_wr_data` is the evicted line.
- R3: While `mem_wr_valid` is 1 and `mem_wr_ack` is 0, the next cycle keeps `mem_wr_valid` at 1 with `mem_wr_addr` and `mem_wr_data` unchanged.
- R4: In a cycle with `mem_wr_valid` and `mem_wr_ack` both 1, `buf_full` is 0 in that same cycle. If no eviction is offered in that cycle, `mem_wr_valid` is 0 in the next cycle.
- R5: A read lookup (`lk_valid`=1, `lk_write`=0) whose address bits above the line offset equal those of the buffered line gives `lk_hit`=1, with `lk_data` equal to the buffered line, whatever its offset bits are. A lookup to any other line, or to an empty buffer, gives `lk_hit`=0 and `lk_data`=0.
- R6: A write lookup (`lk_write`=1) to the buffered line gives `lk_hit`=0 and `lk_wmatch`=1. It does not raise `ev_stall` and leaves the buffered address and data unchanged.
- R7: An eviction offered while the buffer holds an unacknowledged line raises `ev_stall` in that cycle. The offered line is not captured, and the buffered line keeps draining unchanged.
- R8: An eviction offered in the cycle that memory acknowledges the buffered line is accepted without a stall. The new line is presented on the memory port in the next cycle.
- R9: `ev_stall` is 1 only while `ev_valid` is 1. Lookups never cause a stall.
- R10: `mem_wr_ack` while the buffer is empty has no effect: the buffer stays empty, and a later eviction drains normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Cache offers a dirty evicted line |
| ev_addr | input | ADDR_W | Byte address of the evicted line |
| ev_data | input | LINE_BYTES*8 | Evicted line contents |
| ev_stall | output | 1 | Eviction refused this cycle; cache must hold it and stall |
| buf_full | output | 1 | Buffer holds a line not yet acknowledged by memory |
| lk_valid | input | 1 | Lookup request from the cache |
| lk_write | input | 1 | Lookup is a write (1) or read (0) |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_hit | output | 1 | Read lookup served from the buffer |
| lk_wmatch | output | 1 | Write lookup falls in the buffered line (treat as miss) |
| lk_data | output | LINE_BYTES*8 | Buffered line on a read hit, else zero |
| mem_wr_valid | output | 1 | Write request to memory |
| mem_wr_addr | output | ADDR_W | Line-aligned memory write address |
| mem_wr_data | output | LINE_BYTES*8 | Memory write data |
| mem_wr_ack | input | 1 | Memory accepts and completes the write |

## Verification
The bench targets the cycle where an acknowledgement and a new eviction coincide. A design that frees the buffer a cycle late would stall there, and one that overwrites first would lose the draining line. It probes write lookups to the buffered line, which a wrong design would report as hits, stall on, or merge into the data being drained. It also checks read hits at non-zero offsets and misses that differ only in the lowest line-address bit, which catch a comparator that includes offset bits or drops a tag bit. Finally, it sends a stray acknowledgement to an empty buffer, which a careless state machine would turn into a phantom drain.

// File: rtl/wb_pkg.sv
package wb_pkg;

    localparam int WB_ADDR_W_DEF     = 32;
    localparam int WB_LINE_BYTES_DEF = 64;

    typedef enum logic {
        WB_EMPTY = 1'b0,
        WB_DRAIN = 1'b1
    } wb_state_e;

    typedef struct packed {
        logic accept;
        logic stall;
        logic release_line;
    } wb_ctrl_t;

endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
    import wb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ev_valid,
    input  logic     mem_ack,
    output logic     occupied,
    output logic     full,
    output wb_ctrl_t ctl
);

    wb_state_e st_q, st_d;

    assign occupied = (st_q == WB_DRAIN);

    always_comb begin
        ctl.release_line = occupied && mem_ack;
        full             = occupied && !mem_ack;
        ctl.accept       = ev_valid && !full;
        ctl.stall        = ev_valid && full;
        st_d             = st_q;
        if (ctl.accept)
            st_d = WB_DRAIN;
        else if (ctl.release_line)
            st_d = WB_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= WB_EMPTY;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/wb_store.sv
module wb_store #(
    parameter int LA_W       = 26,
    parameter int LINE_BYTES = 64,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LA_W-1:0]   tag_d,
    input  logic [LINE_W-1:0] data_d,
    output logic [LA_W-1:0]   tag_q,
    output logic [LINE_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst)
            tag_q <= '0;
        else if (load)
            tag_q <= tag_d;
    end

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (load)
                q <= data_d[g*8 +: 8];
        end
        assign data_q[g*8 +: 8] = q;
    end

endmodule

// File: rtl/wb_lookup.sv
module wb_lookup #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFS_W,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              occupied,
    input  logic [LA_W-1:0]   tag,
    input  logic [LINE_W-1:0] line,
    output logic              hit,
    output logic              wmatch,
    output logic [LINE_W-1:0] data
);

    logic same_line;

    always_comb begin
        same_line = occupied && lk_valid && (lk_addr[ADDR_W-1:OFS_W] == tag);
        hit       = same_line && !lk_write;
        wmatch    = same_line && lk_write;
        data      = hit ? line : '0;
    end

endmodule

// File: rtl/wb_line_buf.sv
module wb_line_buf
    import wb_pkg::*;
#(
    parameter int ADDR_W     = WB_ADDR_W_DEF,
    parameter int LINE_BYTES = WB_LINE_BYTES_DEF,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFS_W,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [LINE_W-1:0] ev_data,
    output logic              ev_stall,
    output logic              buf_full,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_wmatch,
    output logic [LINE_W-1:0] lk_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [LINE_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);

    logic              occupied;
    wb_ctrl_t          ctl;
    logic [LA_W-1:0]   tag_q;
    logic [LINE_W-1:0] line_q;

    wb_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .mem_ack  (mem_wr_ack),
        .occupied (occupied),
        .full     (buf_full),
        .ctl      (ctl)
    );

    wb_store #(.LA_W(LA_W), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.accept),
        .tag_d  (ev_addr[ADDR_W-1:OFS_W]),
        .data_d (ev_data),
        .tag_q  (tag_q),
        .data_q (line_q)
    );

    wb_lookup #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_lookup (
        .lk_valid (lk_valid),
        .lk_write (lk_write),
        .lk_addr  (lk_addr),
        .occupied (occupied),
        .tag      (tag_q),
        .line     (line_q),
        .hit      (lk_hit),
        .wmatch   (lk_wmatch),
        .data     (lk_data)
    );

    assign ev_stall     = ctl.stall;
    assign mem_wr_valid = occupied;
    assign mem_wr_addr  = {tag_q, {OFS_W{1'b0}}};
    assign mem_wr_data  = line_q;

endmodule

// File: rtl/wb_line_buf_chk.sv
module wb_line_buf_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic [ADDR_W-1:0] ev_addr,
    input logic              ev_stall,
    input logic              buf_full,
    input logic              lk_valid,
    input logic              lk_write,
    input logic              lk_hit,
    input logic [LINE_W-1:0] lk_data,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [LINE_W-1:0] mem_wr_data,
    input logic              mem_wr_ack
);

    logic [ADDR_W-1:0] ev_aligned;
    assign ev_aligned = {ev_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_wr_valid && !buf_full)); // R1

    AST_DRAIN_NEXT: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !buf_full) |=> (mem_wr_valid && mem_wr_addr == $past(ev_aligned))); // R2

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ack) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R3

    AST_FREE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ack) |-> !buf_full); // R4

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ack && !ev_valid) |=> !mem_wr_valid); // R4

    AST_HIT_DATA: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (mem_wr_valid && lk_data == mem_wr_data)); // R5

    AST_WRITE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_write) |-> !lk_hit); // R6

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ev_stall |-> (ev_valid && mem_wr_valid && !mem_wr_ack)); // R7

    AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |-> !ev_stall); // R9

endmodule

bind wb_line_buf wb_line_buf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (ev_valid),
    .ev_addr      (ev_addr),
    .ev_stall     (ev_stall),
    .buf_full     (buf_full),
    .lk_valid     (lk_valid),
    .lk_write     (lk_write),
    .lk_hit       (lk_hit),
    .lk_data      (lk_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack)
);

// File: tb/sim_wb_line_buf.sv
`timescale 1ns/1ps
module sim_wb_line_buf;

    localparam int AW = 32;
    localparam int LB = 64;
    localparam int LW = LB * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          ev_valid;
    logic [AW-1:0] ev_addr;
    logic [LW-1:0] ev_data;
    logic          ev_stall, buf_full;
    logic          lk_valid, lk_write;
    logic [AW-1:0] lk_addr;
    logic          lk_hit, lk_wmatch;
    logic [LW-1:0] lk_data;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [LW-1:0] mem_wr_data;
    logic          mem_wr_ack;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    wb_line_buf #(.ADDR_W(AW), .LINE_BYTES(LB)) u0 (.*);

    function automatic logic [LW-1:0] mk_line(input logic [31:0] seed);
        logic [LW-1:0] v;
        for (int i = 0; i < LW / 32; i++)
            v[i*32 +: 32] = seed * 32'h0101_0101 + 32'(i);
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    localparam logic [AW-1:0] A_ADDR = 32'h1234_5678;
    localparam logic [AW-1:0] B_ADDR = 32'h0000_0FC0;
    localparam logic [AW-1:0] C_ADDR = 32'h7FFF_FF81;

    task automatic t_reset();
        rst = 1; ev_valid = 0; ev_addr = '0; ev_data = '0;
        lk_valid = 0; lk_write = 0; lk_addr = '0; mem_wr_ack = 0;
        repeat (3) step();
        rst = 0;
        step();
        lk_valid = 1; lk_addr = 32'h0;
        #1;
        chk("R1", "buf_full", LW'(buf_full), LW'(0));
        chk("R1", "mem_wr_valid", LW'(mem_wr_valid), LW'(0));
        chk("R1", "ev_stall", LW'(ev_stall), LW'(0));
        chk("R1", "lk_hit", LW'(lk_hit), LW'(0));
        lk_valid = 0;
    endtask

    task automatic t_enqueue();
        step();
        ev_valid = 1; ev_addr = A_ADDR; ev_data = mk_line(32'hA1);
        #1;
        chk("R9", "stall on empty", LW'(ev_stall), LW'(0));
        step();
        ev_valid = 0;
        #1;
        chk("R2", "mem_wr_valid", LW'(mem_wr_valid), LW'(1));
        chk("R2", "buf_full", LW'(buf_full), LW'(1));
        chk("R2", "mem_wr_addr", LW'(mem_wr_addr), LW'(32'h1234_5640));
        chk("R2", "mem_wr_data", mem_wr_data, mk_line(32'hA1));
        repeat (3) step();
        chk("R3", "hold valid", LW'(mem_wr_valid), LW'(1));
        chk("R3", "hold addr", LW'(mem_wr_addr), LW'(32'h1234_5640));
        chk("R3", "hold data", mem_wr_data, mk_line(32'hA1));
    endtask

    task automatic t_read_lookup();
        lk_valid = 1; lk_write = 0; lk_addr = 32'h1234_5641;
        #1;
        chk("R5", "hit other offset", LW'(lk_hit), LW'(1));
        chk("R5", "hit data", lk_data, mk_line(32'hA1));
        lk_addr = 32'h1234_5600;
        #1;
        chk("R5", "miss adjacent line", LW'(lk_hit), LW'(0));
        chk("R5", "miss data zero", lk_data, '0);
        lk_addr = 32'h9234_567F;
        #1;
        chk("R5", "miss top bit", LW'(lk_hit), LW'(0));
        chk("R9", "lookup no stall", LW'(ev_stall), LW'(0));
        lk_valid = 0;
    endtask

    task automatic t_write_lookup();
        step();
        lk_valid = 1; lk_write = 1; lk_addr = 32'h1234_5650;
        #1;
        chk("R6", "write hit", LW'(lk_hit), LW'(0));
        chk("R6", "write match", LW'(lk_wmatch), LW'(1));
        chk("R6", "write stall", LW'(ev_stall), LW'(0));
        step();
        lk_write = 0; lk_addr = 32'h1234_5650;
        #1;
        chk("R6", "data unchanged mem", mem_wr_data, mk_line(32'hA1));
        chk("R6", "data unchanged lookup", lk_data, mk_line(32'hA1));
        chk("R6", "addr unchanged", LW'(mem_wr_addr), LW'(32'h1234_5640));
        lk_valid = 0;
    endtask

    task automatic t_evict_stall();
        step();
        ev_valid = 1; ev_addr = B_ADDR; ev_data = mk_line(32'hB2);
        #1;
        chk("R7", "stall", LW'(ev_stall), LW'(1));
        step();
        #1;
        chk("R7", "still stall", LW'(ev_stall), LW'(1));
        chk("R7", "old addr kept", LW'(mem_wr_addr), LW'(32'h1234_5640));
        chk("R7", "old data kept", mem_wr_data, mk_line(32'hA1));
        ev_valid = 0;
    endtask

    task automatic t_ack_free();
        step();
        mem_wr_ack = 1;
        #1;
        chk("R4", "full drops on ack", LW'(buf_full), LW'(0));
        chk("R4", "valid during ack", LW'(mem_wr_valid), LW'(1));
        step();
        mem_wr_ack = 0;
        #1;
        chk("R4", "valid released", LW'(mem_wr_valid), LW'(0));
        chk("R4", "full released", LW'(buf_full), LW'(0));
        lk_valid = 1; lk_write = 0; lk_addr = A_ADDR;
        #1;
        chk("R5", "no hit when empty", LW'(lk_hit), LW'(0));
        lk_valid = 0;
    endtask

    task automatic t_stray_ack();
        step();
        mem_wr_ack = 1;
        step();
        mem_wr_ack = 0;
        #1;
        chk("R10", "empty after stray ack", LW'(mem_wr_valid), LW'(0));
        chk("R10", "full after stray ack", LW'(buf_full), LW'(0));
        ev_valid = 1; ev_addr = B_ADDR; ev_data = mk_line(32'hB2);
        step();
        ev_valid = 0;
        #1;
        chk("R10", "drain after stray ack", LW'(mem_wr_addr), LW'(32'h0000_0FC0));
        chk("R10", "valid after stray ack", LW'(mem_wr_valid), LW'(1));
    endtask

    task automatic t_ack_and_evict();
        step();
        mem_wr_ack = 1;
        ev_valid = 1; ev_addr = C_ADDR; ev_data = mk_line(32'hC3);
        #1;
        chk("R8", "no stall on ack cycle", LW'(ev_stall), LW'(0));
        step();
        mem_wr_ack = 0; ev_valid = 0;
        #1;
        chk("R8", "new valid", LW'(mem_wr_valid), LW'(1));
        chk("R8", "new addr", LW'(mem_wr_addr), LW'(32'h7FFF_FF80));
        chk("R8", "new data", mem_wr_data, mk_line(32'hC3));
        step();
        mem_wr_ack = 1;
        step();
        mem_wr_ack = 0;
        #1;
        chk("R4", "final empty", LW'(mem_wr_valid), LW'(0));
    endtask

    initial begin
        t_reset();
        t_enqueue();
        t_read_lookup();
        t_write_lookup();
        t_evict_stall();
        t_ack_free();
        t_stray_ack();
        t_ack_and_evict();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule